// File: doc/BRIEF.md
# SPI Stream CRC Accumulator

This block sits beside an SPI shift engine and folds the serial data stream into a running CRC, one bit per sampled clock edge. The engine raises a bit-valid strobe for each bit that belongs to a transferred byte. On every strobe the accumulator takes the bit from the line chosen by a source select (the outgoing or the incoming data line), most significant bit first, and advances both a 7-bit and a 16-bit checksum. A mode select picks which of the two is presented at the output.

Software resets the checksum with a clear write and reads the value back at any time. The same register serves both directions. For generation it watches the outgoing line, and the value read is then sent after the data block. For checking it watches the incoming line, and two further received CRC bytes are clocked in; a value of zero afterwards means the block arrived intact. In 7-bit mode the value sits in the low seven bits. Software forms the wire byte itself as the value shifted left by one with a 1 appended. In 16-bit mode the high byte goes out first.

Top module: `spi_crc_unit`

## Requirements
- R1: With mode_i = 0 the output carries in bits 6:0 the 7-bit CRC (polynomial x^7 + x^3 + 1, initial value 0, MSB first) of all bits sampled since the last clear, with bits 15:7 at zero. The five bytes 0x40 0x00 0x00 0x00 0x00 give 0x4A.
- R2: With mode_i = 1 the output carries the 16-bit CRC (polynomial x^16 + x^12 + x^5 + 1, initial value 0, MSB first) of all bits sampled since the last clear. The ASCII bytes "123456789" give 0x31C3.
- R3: Each cycle with bit_valid_i = 1 folds in exactly one bit, taken from mosi_i when src_i = 0 and from miso_i when src_i = 1. The output reflects it in the next cycle.
- R4: clr_i = 1 sets the value to zero in the next cycle and takes priority over a bit sampled in the same cycle.
- R5: In cycles with bit_valid_i = 0 and clr_i = 0 the value holds, whatever the data lines do.
- R6: After reset the output is zero.
- R7: Changing mode_i or src_i does not clear anything. Both widths keep accumulating over every sampled bit since the last clear, and mode_i only chooses which one is shown.
- R8: In 16-bit mode, clocking in the high byte and then the low byte of the current CRC leaves the output at zero.
- R9: In 7-bit mode, clocking in the seven bits of the current CRC, MSB first, leaves the output at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | One data bit is sampled this cycle |
| mosi_i | input | 1 | Bit on the outgoing data line |
| miso_i | input | 1 | Bit on the incoming data line |
| mode_i | input | 1 | 0: 7-bit CRC shown, 1: 16-bit CRC shown |
| src_i | input | 1 | 0: sample mosi_i, 1: sample miso_i |
| clr_i | input | 1 | Clear write: reset the accumulator to zero |
| crc_o | output | 16 | Current CRC value |

## Verification
The hardest situations to reach are those where the mode or source changes in the middle of a stream, and a clear that lands on the same cycle as a sampled bit. The stimulus splits one fixed command across a source switch and across a mode switch, with gaps in which the data lines toggle. It then checks that the known 7-bit result still appears. It also closes each known data block with its own CRC bytes to reach the zero residue in both widths.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int CRC_OUT_W = 16;
  localparam int CRC_S_W   = 7;
  localparam int CRC_L_W   = 16;
  localparam logic [CRC_S_W-1:0] CRC_S_POLY = 7'h09;
  localparam logic [CRC_L_W-1:0] CRC_L_POLY = 16'h1021;

  typedef enum logic {
    CRC_SHORT = 1'b0,
    CRC_LONG  = 1'b1
  } crc_mode_e;

  typedef enum logic {
    SRC_OUT_LINE = 1'b0,
    SRC_IN_LINE  = 1'b1
  } crc_src_e;
endpackage

// File: rtl/spi_crc_src_sel.sv
module spi_crc_src_sel
  import spi_crc_pkg::*;
(
  input  logic mosi_i,
  input  logic miso_i,
  input  logic src_i,
  output logic bit_o
);
  crc_src_e src;

  always_comb begin
    src   = crc_src_e'(src_i);
    bit_o = (src == SRC_IN_LINE) ? miso_i : mosi_i;
  end
endmodule

// File: rtl/spi_crc_lane.sv
module spi_crc_lane #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[W-1] ^ bit_i;
    crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= '0;
    else if (clr_i)    crc_q <= '0;  // clear wins over a same-cycle bit
    else if (shift_i)  crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == '0);  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !shift_i) |=> $stable(crc_q));  // R5
  AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && shift_i && crc_q == '0 && !bit_i) |=> crc_q == '0);  // R3
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
  import spi_crc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_valid_i,
  input  logic                 mosi_i,
  input  logic                 miso_i,
  input  logic                 mode_i,
  input  logic                 src_i,
  input  logic                 clr_i,
  output logic [CRC_OUT_W-1:0] crc_o
);
  logic               sel_bit;
  logic [CRC_S_W-1:0] crc_s;
  logic [CRC_L_W-1:0] crc_l;
  crc_mode_e          mode;

  spi_crc_src_sel u_src (
    .mosi_i (mosi_i),
    .miso_i (miso_i),
    .src_i  (src_i),
    .bit_o  (sel_bit)
  );

  // both widths always run so a mode switch loses nothing
  spi_crc_lane #(.W(CRC_S_W), .POLY(CRC_S_POLY)) u_lane_s (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .shift_i (bit_valid_i),
    .bit_i   (sel_bit),
    .crc_o   (crc_s)
  );

  spi_crc_lane #(.W(CRC_L_W), .POLY(CRC_L_POLY)) u_lane_l (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .shift_i (bit_valid_i),
    .bit_i   (sel_bit),
    .crc_o   (crc_l)
  );

  always_comb begin
    mode  = crc_mode_e'(mode_i);
    crc_o = (mode == CRC_LONG) ? crc_l
                               : {{(CRC_OUT_W-CRC_S_W){1'b0}}, crc_s};
  end

  AST_CLR_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == '0);  // R4
  AST_MODE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !bit_valid_i) |=> (crc_l == $past(crc_l) && crc_s == $past(crc_s)));  // R7
  AST_SHORT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 1'b0) |-> crc_o[CRC_OUT_W-1:CRC_S_W] == '0);  // R1
endmodule

// File: tb/spi_crc_unit_bench.sv
module spi_crc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld = 1'b0, mosi = 1'b0, miso = 1'b0, mode = 1'b0, src = 1'b0, clr = 1'b0;
  logic [15:0] crc_o;

  int    tests = 0, fails = 0;
  bit    done = 0;
  string tag = "R6";
  int    m7 = 0, m16 = 0;

  always #5 clk = ~clk;

  spi_crc_unit u_spi_crc_unit (
    .clk_i(clk), .rst_ni(rst_ni), .bit_valid_i(vld), .mosi_i(mosi),
    .miso_i(miso), .mode_i(mode), .src_i(src), .clr_i(clr), .crc_o(crc_o)
  );

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  // reference: polynomial long division one bit at a time
  task automatic model_bit(int b);
    int t7, t16;
    t7  = ((m7 >> 6) & 1) ^ b;
    m7  = (m7 << 1) & 'h7f;
    if (t7 != 0) m7 = m7 ^ 'h09;
    t16 = ((m16 >> 15) & 1) ^ b;
    m16 = (m16 << 1) & 'hffff;
    if (t16 != 0) m16 = m16 ^ 'h1021;
  endtask

  task automatic cycle();
    int exp;
    @(posedge clk);
    if (clr) begin m7 = 0; m16 = 0; end
    else if (vld) model_bit(src ? int'(miso) : int'(mosi));
    #2;
    exp = mode ? m16 : m7;
    check(tag, crc_o, exp[15:0]);
  endtask

  task automatic send_byte(logic [7:0] v, int gap);
    for (int i = 7; i >= 0; i--) begin
      vld = 1'b1;
      if (src) begin miso = v[i]; mosi = ~v[i]; end
      else     begin mosi = v[i]; miso = ~v[i]; end
      cycle();
    end
    vld = 1'b0;
    for (int g = 0; g < gap; g++) begin
      mosi = ~mosi; miso = ~miso;
      cycle();
    end
  endtask

  task automatic do_clear();
    clr = 1'b1; cycle(); clr = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin : main
    logic [15:0] c;
    #12 rst_ni = 1'b1;
    tag = "R6"; cycle(); check("R6", crc_o, 16'h0000);

    // R1: known 7-bit command checksum
    tag = "R1"; mode = 1'b0; src = 1'b0;
    send_byte(8'h40, 0);
    for (int k = 0; k < 4; k++) send_byte(8'h00, 0);
    check("R1", crc_o, 16'h004A);
    // R9: 7-bit residue
    tag = "R9";
    for (int i = 6; i >= 0; i--) begin
      vld = 1'b1; mosi = c7bit(i); cycle();
    end
    vld = 1'b0; cycle();
    check("R9", crc_o, 16'h0000);

    // R2: known 16-bit checksum over "123456789"
    tag = "R4"; do_clear(); check("R4", crc_o, 16'h0000);
    tag = "R2"; mode = 1'b1;
    for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k), 0);
    check("R2", crc_o, 16'h31C3);

    // R8: residue on the incoming line
    tag = "R8"; src = 1'b1;
    c = crc_o;
    send_byte(c[15:8], 0);
    send_byte(c[7:0], 0);
    check("R8", crc_o, 16'h0000);

    // R5: gaps with toggling lines
    tag = "R5"; do_clear(); src = 1'b0;
    send_byte(8'hA5, 3);
    c = crc_o;
    vld = 1'b0;
    for (int g = 0; g < 5; g++) begin mosi = ~mosi; miso = ~miso; cycle(); end
    check("R5", crc_o, c);
    send_byte(8'h3C, 2);

    // R3: source switch mid-stream
    tag = "R3"; do_clear(); mode = 1'b0; src = 1'b0;
    send_byte(8'h40, 1);
    src = 1'b1;
    for (int k = 0; k < 4; k++) send_byte(8'h00, 1);
    check("R3", crc_o, 16'h004A);

    // R7: mode switch mid-stream keeps both widths running
    tag = "R7"; do_clear(); mode = 1'b0; src = 1'b0;
    send_byte(8'h40, 0);
    send_byte(8'h00, 0);
    mode = 1'b1; cycle();
    send_byte(8'h00, 0);
    src = 1'b1; send_byte(8'h00, 0);
    mode = 1'b0; send_byte(8'h00, 0);
    check("R7", crc_o, 16'h004A);
    check("R1", {7'h00, crc_o[15:7]}, 16'h0000);

    // R4: clear together with a sampled bit
    tag = "R4"; mode = 1'b1; src = 1'b0;
    send_byte(8'hFF, 0);
    clr = 1'b1; vld = 1'b1; mosi = 1'b1; cycle();
    clr = 1'b0; vld = 1'b0;
    check("R4", crc_o, 16'h0000);
    tag = "R2"; send_byte(8'h5A, 1);

    done = 1;
    summary();
    $finish;
  end

  function automatic logic c7bit(int i);
    logic [6:0] v = 7'h4A;
    return v[i];
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule